// File: doc/BRIEF.md
# Packed Byte Sum-of-Absolute-Differences Execute Unit

This unit carries out one instruction of a 32-bit core: it splits two source registers into four unsigned bytes each, takes the absolute difference of each byte pair and adds the four differences together. In the accumulating form the value of a third register is added to that total. The plain form and the accumulating form share one datapath. An accumulator index of 15 selects the plain form.

The unit takes an instruction word, the current N/Z/C/V flags and the current program counter. It drives three register-file read addresses taken from the instruction and receives the read data back in the same cycle. Execution depends on a 4-bit condition field. When the instruction executes, the unit returns a write enable, a destination index and the result one clock later. The incremented program counter is returned whether the condition passes or fails.

Top module: `sad_exec_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `out_valid` and `wr_en` are 0 after that edge.
- R2: The read addresses are combinational copies of instruction fields: `rd_addr_a` = bits 3:0, `rd_addr_b` = bits 11:8 and `rd_addr_c` = bits 15:12.
- R3: The result is the sum, taken as 32 bits, of the unsigned absolute differences of the byte pairs of `rd_data_a` and `rd_data_b` in lanes 7:0, 15:8, 23:16 and 31:24.
- R4: When bits 15:12 are not 15, `rd_data_c` is added to the byte sum, and the addition wraps modulo 2^32.
- R5: When bits 15:12 equal 15, nothing is added to the byte sum, whatever `rd_data_c` holds.
- R6: The condition is bits 31:28, and `flags` is {N,Z,C,V} with N at bit 3. The codes are: 0 Z, 1 !Z, 2 C, 3 !C, 4 N, 5 !N, 6 V, 7 !V, 8 C&!Z, 9 !C|Z, 10 N==V, 11 N!=V, 12 !Z&(N==V), 13 Z|(N!=V). Code 14 always passes and code 15 never passes.
- R7: `wr_idx` is bits 19:16. `wr_en` is 1 only for a valid instruction whose condition passes and whose opcode matches.
- R8: The opcode matches only when bits 27:20 equal 8'h78 and bits 7:4 equal 4'h1. Any other opcode gives no write.
- R9: For every valid instruction, `pc_next` equals `pc_in` + 4, whether the condition passes or not.
- R10: All outputs are registered. `out_valid` follows `in_valid` one cycle later, and a cycle without `in_valid` gives `out_valid` = 0 and `wr_en` = 0 after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Instruction present this cycle |
| instr | input | 32 | Instruction word |
| flags | input | 4 | Condition flags {N,Z,C,V} |
| pc_in | input | 32 | Current program counter |
| rd_addr_a | output | 4 | First operand read address |
| rd_data_a | input | 32 | First operand read data |
| rd_addr_b | output | 4 | Second operand read address |
| rd_data_b | input | 32 | Second operand read data |
| rd_addr_c | output | 4 | Accumulator read address |
| rd_data_c | input | 32 | Accumulator read data |
| out_valid | output | 1 | Registered result slot valid |
| wr_en | output | 1 | Register write enable |
| wr_idx | output | 4 | Destination register index |
| wr_data | output | 32 | Result value |
| pc_next | output | 32 | Advanced program counter |

## Verification
The assertions assume that `in_valid` and, when it is high, `instr` and `pc_in` are known values. They also assume that the read data answers the addresses driven in the same cycle and stays steady until the capturing edge. The bench meets these assumptions by driving all inputs on the falling edge. It serves the read data combinationally from a register array indexed by the unit's own read addresses, and it changes that array only on a falling edge, after the previous instruction has been captured.

// File: rtl/sad_pkg.sv
package sad_pkg;

    localparam int INSTR_W   = 32;
    localparam int IDX_W     = 4;
    localparam logic [7:0] OP_HI_SAD  = 8'h78;
    localparam logic [3:0] OP_LO_SAD  = 4'h1;
    localparam logic [IDX_W-1:0] NO_ACC_IDX = 4'hF;

    typedef enum logic [3:0] {
        CC_ZSET = 4'h0, CC_ZCLR = 4'h1, CC_CSET = 4'h2, CC_CCLR = 4'h3,
        CC_NSET = 4'h4, CC_NCLR = 4'h5, CC_VSET = 4'h6, CC_VCLR = 4'h7,
        CC_UHI  = 4'h8, CC_ULS  = 4'h9, CC_SGE  = 4'hA, CC_SLT  = 4'hB,
        CC_SGT  = 4'hC, CC_SLE  = 4'hD, CC_ALW  = 4'hE, CC_NEV  = 4'hF
    } cond_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

    typedef struct packed {
        cond_e            cond;
        logic [7:0]       op_hi;
        logic [IDX_W-1:0] dst;
        logic [IDX_W-1:0] acc;
        logic [IDX_W-1:0] src_b;
        logic [3:0]       op_lo;
        logic [IDX_W-1:0] src_a;
    } fields_t;

    function automatic logic cond_pass(input cond_e cc, input flags_t f);
        logic r;
        case (cc)
            CC_ZSET: r = f.z;
            CC_ZCLR: r = !f.z;
            CC_CSET: r = f.c;
            CC_CCLR: r = !f.c;
            CC_NSET: r = f.n;
            CC_NCLR: r = !f.n;
            CC_VSET: r = f.v;
            CC_VCLR: r = !f.v;
            CC_UHI:  r = f.c && !f.z;
            CC_ULS:  r = !f.c || f.z;
            CC_SGE:  r = (f.n == f.v);
            CC_SLT:  r = (f.n != f.v);
            CC_SGT:  r = !f.z && (f.n == f.v);
            CC_SLE:  r = f.z || (f.n != f.v);
            CC_ALW:  r = 1'b1;
            default: r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/sad_decode.sv
module sad_decode
    import sad_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output fields_t            fields,
    output logic               is_sad
);
    always_comb begin
        fields = fields_t'(instr);
        is_sad = (fields.op_hi == OP_HI_SAD) && (fields.op_lo == OP_LO_SAD);
    end
endmodule

// File: rtl/sad_cond_eval.sv
module sad_cond_eval
    import sad_pkg::*;
(
    input  cond_e  cond,
    input  flags_t flags,
    output logic   pass
);
    always_comb pass = cond_pass(cond, flags);
endmodule

// File: rtl/sad_lane_sum.sv
module sad_lane_sum #(
    parameter int DATA_W = 32,
    parameter int LANE_W = 8
) (
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic [DATA_W-1:0] addend,
    output logic [DATA_W-1:0] total
);
    localparam int LANES = DATA_W / LANE_W;

    logic [LANE_W-1:0] diff [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] la, lb;
        always_comb begin
            la = op_a[g*LANE_W +: LANE_W];
            lb = op_b[g*LANE_W +: LANE_W];
            diff[g] = (la > lb) ? (la - lb) : (lb - la);
        end
    end

    always_comb begin
        logic [DATA_W-1:0] acc;
        acc = addend;
        for (int i = 0; i < LANES; i++) begin
            acc = acc + DATA_W'(diff[i]);
        end
        total = acc;
    end
endmodule

// File: rtl/sad_exec_unit.sv
module sad_exec_unit
    import sad_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int LANE_W  = 8,
    parameter int PC_STEP = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [INSTR_W-1:0]  instr,
    input  logic [3:0]          flags,
    input  logic [DATA_W-1:0]   pc_in,
    output logic [IDX_W-1:0]    rd_addr_a,
    input  logic [DATA_W-1:0]   rd_data_a,
    output logic [IDX_W-1:0]    rd_addr_b,
    input  logic [DATA_W-1:0]   rd_data_b,
    output logic [IDX_W-1:0]    rd_addr_c,
    input  logic [DATA_W-1:0]   rd_data_c,
    output logic                out_valid,
    output logic                wr_en,
    output logic [IDX_W-1:0]    wr_idx,
    output logic [DATA_W-1:0]   wr_data,
    output logic [DATA_W-1:0]   pc_next
);
    fields_t            fld;
    logic               is_sad;
    logic               pass;
    logic [DATA_W-1:0]  addend;
    logic [DATA_W-1:0]  result;

    sad_decode u_dec (
        .instr  (instr),
        .fields (fld),
        .is_sad (is_sad)
    );

    sad_cond_eval u_cond (
        .cond  (fld.cond),
        .flags (flags_t'(flags)),
        .pass  (pass)
    );

    assign rd_addr_a = fld.src_a;
    assign rd_addr_b = fld.src_b;
    assign rd_addr_c = fld.acc;

    always_comb addend = (fld.acc == NO_ACC_IDX) ? '0 : rd_data_c;

    sad_lane_sum #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_sum (
        .op_a   (rd_data_a),
        .op_b   (rd_data_b),
        .addend (addend),
        .total  (result)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            wr_en     <= 1'b0;
        end else begin
            out_valid <= in_valid;
            wr_en     <= in_valid && pass && is_sad;
        end
    end

    always_ff @(posedge clk) begin
        if (in_valid) begin
            wr_idx  <= fld.dst;
            wr_data <= result;
            pc_next <= pc_in + DATA_W'(PC_STEP);
        end
    end
endmodule

// File: rtl/sad_exec_checker.sv
module sad_exec_checker (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [31:0] instr,
    input logic [31:0] pc_in,
    input logic        out_valid,
    input logic        wr_en,
    input logic [3:0]  wr_idx,
    input logic [31:0] wr_data,
    input logic [31:0] pc_next
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (!out_valid && !wr_en));

    assert_write_implies_valid_R7: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> out_valid);

    assert_dest_index_R7: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (wr_idx == $past(instr[19:16])));

    assert_never_code_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && instr[31:28] == 4'hF) |=> !wr_en);

    assert_always_code_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && instr[31:28] == 4'hE && instr[27:20] == 8'h78 && instr[7:4] == 4'h1)
        |=> wr_en);

    assert_bad_opcode_R8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (instr[27:20] != 8'h78 || instr[7:4] != 4'h1)) |=> !wr_en);

    assert_plain_bound_R5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && instr[15:12] == 4'hF) |=> (wr_data <= 32'd1020));

    assert_pc_step_R9: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (pc_next == $past(pc_in) + 32'd4));

    assert_valid_follow_R10: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_idle_R10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && !wr_en));
endmodule

bind sad_exec_unit sad_exec_checker u_chk (.*);

// File: tb/tb_sad_exec_unit.sv
`timescale 1ns/1ps
module tb_sad_exec_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [3:0]  flags = '0;
    logic [31:0] pc_in = '0;
    logic [3:0]  rd_addr_a, rd_addr_b, rd_addr_c;
    logic [31:0] rd_data_a, rd_data_b, rd_data_c;
    logic        out_valid, wr_en;
    logic [3:0]  wr_idx;
    logic [31:0] wr_data, pc_next;

    logic [31:0] regs [16];

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic        valid;
        logic        we;
        logic [3:0]  idx;
        logic [31:0] data;
        logic [31:0] pc;
        string       tag;
    } exp_t;

    exp_t expq[$];

    always #4 clk = ~clk;

    assign rd_data_a = regs[rd_addr_a];
    assign rd_data_b = regs[rd_addr_b];
    assign rd_data_c = regs[rd_addr_c];

    sad_exec_unit dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr), .flags(flags),
        .pc_in(pc_in), .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
        .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b), .rd_addr_c(rd_addr_c),
        .rd_data_c(rd_data_c), .out_valid(out_valid), .wr_en(wr_en),
        .wr_idx(wr_idx), .wr_data(wr_data), .pc_next(pc_next)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic ref_pass(input logic [3:0] cc, input logic [3:0] f);
        logic n, z, c, v;
        {n, z, c, v} = f;
        case (cc)
            4'd0:  return z;
            4'd1:  return !z;
            4'd2:  return c;
            4'd3:  return !c;
            4'd4:  return n;
            4'd5:  return !n;
            4'd6:  return v;
            4'd7:  return !v;
            4'd8:  return c && !z;
            4'd9:  return !c || z;
            4'd10: return n == v;
            4'd11: return n != v;
            4'd12: return !z && (n == v);
            4'd13: return z || (n != v);
            4'd14: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [31:0] ref_result(input logic [31:0] x, input logic [31:0] y,
                                               input logic [3:0] ai);
        longint s = 0;
        for (int k = 0; k < 4; k++) begin
            int p = int'((x >> (8 * k)) & 32'hFF);
            int q = int'((y >> (8 * k)) & 32'hFF);
            s += (p > q) ? (p - q) : (q - p);
        end
        if (ai != 4'd15) s += longint'(regs[ai]);
        return s[31:0];
    endfunction

    function automatic logic [31:0] mk(input logic [3:0] cc, input logic [3:0] dst,
                                       input logic [3:0] acc, input logic [3:0] rm,
                                       input logic [3:0] rn);
        return {cc, 8'h78, dst, acc, rm, 4'h1, rn};
    endfunction

    task automatic step(input logic v, input logic [31:0] ins, input logic [3:0] fl,
                        input logic [31:0] pc, input string tag, input logic rnd);
        exp_t e;
        @(negedge clk);
        if (expq.size() > 0) begin
            exp_t o = expq.pop_front();
            check("R10 out_valid", 32'(out_valid), 32'(o.valid));
            check({o.tag, " wr_en"}, 32'(wr_en), 32'(o.we));
            if (o.we) begin
                check("R7 wr_idx", 32'(wr_idx), 32'(o.idx));
                check({o.tag, " wr_data"}, wr_data, o.data);
            end
            if (o.valid) check("R9 pc_next", pc_next, o.pc);
        end
        if (rnd) for (int i = 0; i < 16; i++) regs[i] = $urandom;
        in_valid = v; instr = ins; flags = fl; pc_in = pc;
        e.valid = v;
        e.we    = v && ref_pass(ins[31:28], fl) && ins[27:20] == 8'h78 && ins[7:4] == 4'h1;
        e.idx   = ins[19:16];
        e.data  = ref_result(regs[ins[3:0]], regs[ins[11:8]], ins[15:12]);
        e.pc    = pc + 32'd4;
        e.tag   = tag;
        expq.push_back(e);
        #1;
        if (v) begin
            check("R2 rd_addr_a", 32'(rd_addr_a), 32'(ins[3:0]));
            check("R2 rd_addr_b", 32'(rd_addr_b), 32'(ins[11:8]));
            check("R2 rd_addr_c", 32'(rd_addr_c), 32'(ins[15:12]));
        end
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) regs[i] = 32'h11111111 * i;
        regs[1]  = 32'h12345678;
        regs[2]  = 32'h87654321;
        regs[3]  = 32'hFF00FF00;
        regs[4]  = 32'h00FF00FF;
        regs[5]  = 32'h00001000;
        regs[14] = 32'hFFFFFFFF;
        regs[15] = 32'h3C3C3C3C;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 out_valid", 32'(out_valid), 32'd0);
        check("R1 wr_en", 32'(wr_en), 32'd0);
        rst = 1'b0;

        step(1, mk(4'hE, 4'd6, 4'hF, 4'd2, 4'd1), 4'h0, 32'h100, "R3", 0);
        step(1, mk(4'hE, 4'd7, 4'hF, 4'd4, 4'd3), 4'h0, 32'h104, "R3", 0);
        step(1, mk(4'hE, 4'd8, 4'hF, 4'd3, 4'd3), 4'h0, 32'h108, "R3", 0);
        step(1, mk(4'hE, 4'd9, 4'd5, 4'd2, 4'd1), 4'h0, 32'h10C, "R4", 0);
        step(1, mk(4'hE, 4'd9, 4'd14, 4'd4, 4'd3), 4'h0, 32'h110, "R4", 0);
        step(1, mk(4'hE, 4'd0, 4'hF, 4'd15, 4'd3), 4'h0, 32'h114, "R5", 0);
        step(0, 32'h0, 4'h0, 32'h0, "R10", 0);
        step(1, mk(4'hE, 4'd10, 4'hF, 4'd2, 4'd1), 4'h0, 32'hFFFFFFFC, "R9", 0);

        for (int c = 0; c < 16; c++)
            for (int f = 0; f < 16; f++)
                step(1, mk(4'(c), 4'(f), 4'(c), 4'(f), 4'(c + f)), 4'(f),
                     32'h2000 + 32'(c * 64 + f * 4), "R6", 0);

        step(1, mk(4'hE, 4'd1, 4'hF, 4'd2, 4'd1) ^ 32'h00000010, 4'h0, 32'h300, "R8", 0);
        step(1, mk(4'hE, 4'd1, 4'hF, 4'd2, 4'd1) ^ 32'h01000000, 4'h0, 32'h304, "R8", 0);
        step(1, mk(4'hE, 4'd1, 4'hF, 4'd2, 4'd1) ^ 32'h00000080, 4'h0, 32'h308, "R8", 0);
        step(0, 32'hFFFFFFFF, 4'hF, 32'h0, "R10", 0);

        for (int n = 0; n < 200; n++) begin
            logic [31:0] w = $urandom;
            w[27:20] = 8'h78;
            w[7:4]   = 4'h1;
            step(1, w, 4'($urandom), $urandom, "R3", 1);
        end
        step(0, 32'h0, 4'h0, 32'h0, "R10", 0);
        step(0, 32'h0, 4'h0, 32'h0, "R10", 0);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule